// File: doc/BRIEF.md
# Row Dark-Offset Correction Engine

This block sits between an image sensor and a host processor. When the host issues a capture command, the engine collects one sensor row at a time. Each row starts with a small group of light-shielded reference pixels and is followed by the active pixels. The engine averages the reference pixels of that row to get the row's dark offset. It then subtracts that offset from every active pixel of the same row, clamping at zero, and stores the corrected row in a frame memory.

A sequencer steps through five phases: idle, collect row, derive offset, correct row, and advance row. After the last row it returns to idle and raises a completion flag. The host reads the corrected frame, the completion flag and nothing else over a byte-wide memory-mapped bus. Reads return data one clock after the read strobe.

The frame size, the reference count, the pixel width and the bus addresses are parameters. The active column count and the reference count must be powers of two.

Top module: `rowbias_engine`

## Requirements
- R1: After reset the sequencer is idle and the completion flag reads 0. Until the first read, `bus_rdata` is 0.
- R2: A bus write of the byte 0x01 to address 0x8000 starts a frame and clears the completion flag. Such a write is ignored unless the engine is idle, so it neither restarts the row count nor disturbs the frame in progress.
- R3: Each row consists of 66 accepted pixel strobes. The first 2 strobes are reference pixels. The remaining 64 strobes are active columns 0 to 63 in order, and active column c of row r is stored at frame address r*64+c.
- R4: The row offset is the sum of the row's two reference pixels shifted right by one, rounding down.
- R5: Each stored pixel equals the active pixel minus the row offset. When the pixel is below the offset, the stored value is 0.
- R6: Pixel strobes are accepted only while a row is being collected. Strobes that arrive while idle, while the offset is being derived or while a row is being corrected are dropped.
- R7: When the 64th row has been stored, the sequencer returns to idle and bit 0 of the status byte at address 0x8001 reads 1. The other status bits read 0.
- R8: A read strobe at a frame address below 0x1000 returns the stored pixel on `bus_rdata` in the following cycle. A read at any other address except the status address returns 0. `bus_rdata` holds its value until the next read.
- R9: Once a frame has completed, a later capture command clears the flag, runs a new frame, and overwrites the stored contents.
- R10: After a row's last pixel, the engine is ready to collect the next row within 70 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_data | input | 8 | Sensor pixel value |
| pix_valid | input | 1 | Pixel strobe |
| bus_addr | input | 16 | Host bus address |
| bus_wr | input | 1 | Host write strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rd | input | 1 | Host read strobe |
| bus_rdata | output | 8 | Host read data, one cycle after the read strobe |

## Verification
On every cycle, the assertions check the following:
- how the sequencer moves between phases;
- that a capture command is taken only when the engine is idle;
- that the column count is frozen outside row collection;
- that the completion flag rises only when the final row is advanced;
- that no corrected value exceeds its raw pixel.

The actual values are shown only by the bench's scenarios. These are the floor-rounded offset, the clamping of pixels that fall below a large offset, and the placement of every column in the frame. The scenarios also show that strobes injected while a row is being corrected leave the stored frame intact, and that a capture command issued mid-frame does not restart it.

// File: rtl/rowbias_pkg.sv
package rowbias_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_COLLECT,
    PH_OFFSET,
    PH_CORRECT,
    PH_ADVANCE
  } phase_t;

  localparam logic [7:0] CMD_CAPTURE = 8'h01;
endpackage

// File: rtl/rowbias_ctrl.sv
module rowbias_ctrl
  import rowbias_pkg::*;
#(
  parameter int ROWS = 64,
  parameter int COLS = 64,
  parameter int REFS = 2,
  localparam int TOT   = REFS + COLS,
  localparam int COL_W = $clog2(TOT),
  localparam int FC_W  = $clog2(COLS),
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             pix_valid,
  output phase_t           phase,
  output logic             take,
  output logic [COL_W-1:0] in_col,
  output logic             offset_load,
  output logic             fix_we,
  output logic [FC_W-1:0]  fix_col,
  output logic [ROW_W-1:0] row,
  output logic             done
);
  assign take        = (phase == PH_COLLECT) && pix_valid;
  assign offset_load = (phase == PH_OFFSET);
  assign fix_we      = (phase == PH_CORRECT);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      in_col  <= '0;
      fix_col <= '0;
      row     <= '0;
      done    <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          done   <= 1'b0;
          row    <= '0;
          in_col <= '0;
          phase  <= PH_COLLECT;
        end
        PH_COLLECT: if (pix_valid) begin
          if (in_col == COL_W'(TOT - 1)) begin
            in_col <= '0;
            phase  <= PH_OFFSET;
          end else begin
            in_col <= in_col + 1'b1;
          end
        end
        PH_OFFSET: begin
          fix_col <= '0;
          phase   <= PH_CORRECT;
        end
        PH_CORRECT: begin
          fix_col <= fix_col + 1'b1;
          if (fix_col == FC_W'(COLS - 1)) phase <= PH_ADVANCE;
        end
        PH_ADVANCE: begin
          if (row == ROW_W'(ROWS - 1)) begin
            done  <= 1'b1;
            phase <= PH_IDLE;
          end else begin
            row   <= row + 1'b1;
            phase <= PH_COLLECT;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R2
  capture_start_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && start) |=> (phase == PH_COLLECT && !done && row == '0));

  // R2
  busy_capture_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_COLLECT && start && !pix_valid) |=> ($stable(in_col) && $stable(row)));

  // R3
  row_end_chk: assert property (@(posedge clk) disable iff (rst)
    (take && in_col == COL_W'(TOT - 1)) |=> (phase == PH_OFFSET));

  // R6
  col_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_COLLECT) |=> $stable(in_col));

  // R7
  done_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(phase) == PH_ADVANCE && $past(row) == ROW_W'(ROWS - 1)));

  // R10
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ADVANCE && row != ROW_W'(ROWS - 1)) |=> (phase == PH_COLLECT));
endmodule

// File: rtl/rowbias_rowbuf.sv
module rowbias_rowbuf #(
  parameter int PIX_W = 8,
  parameter int COLS  = 64,
  parameter int REFS  = 2,
  localparam int TOT   = REFS + COLS,
  localparam int COL_W = $clog2(TOT),
  localparam int FC_W  = $clog2(COLS),
  localparam int RSH   = $clog2(REFS),
  localparam int SUM_W = PIX_W + RSH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [COL_W-1:0] in_col,
  input  logic [PIX_W-1:0] pix,
  input  logic             offset_load,
  input  logic [FC_W-1:0]  rd_col,
  output logic [PIX_W-1:0] rd_pix,
  output logic [PIX_W-1:0] offset
);
  logic [PIX_W-1:0] line [COLS];
  logic [SUM_W-1:0] ref_sum;
  logic [PIX_W-1:0] avg;
  logic [COL_W-1:0] act_idx;

  assign act_idx = in_col - COL_W'(REFS);

  always_ff @(posedge clk) begin
    if (take && in_col >= COL_W'(REFS)) line[act_idx[FC_W-1:0]] <= pix;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_sum <= '0;
    end else if (take && in_col < COL_W'(REFS)) begin
      ref_sum <= (in_col == '0) ? SUM_W'(pix) : ref_sum + SUM_W'(pix);
    end
  end

  generate
    if (RSH == 0) begin : g_single_ref
      assign avg = ref_sum;
    end else begin : g_multi_ref
      logic [SUM_W-1:0] shifted;
      assign shifted = ref_sum >> RSH;
      assign avg     = shifted[PIX_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) offset <= '0;
    else if (offset_load) offset <= avg;
  end

  assign rd_pix = line[rd_col];
endmodule

// File: rtl/rowbias_frame_mem.sv
module rowbias_frame_mem #(
  parameter int DW = 8,
  parameter int AW = 12,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rowbias_engine.sv
module rowbias_engine
  import rowbias_pkg::*;
#(
  parameter int          PIX_W     = 8,
  parameter int          ROWS      = 64,
  parameter int          COLS      = 64,
  parameter int          REFS      = 2,
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] CMD_ADDR  = 16'h8000,
  parameter logic [15:0] STAT_ADDR = 16'h8001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              pix_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata
);
  localparam int TOT    = REFS + COLS;
  localparam int COL_W  = $clog2(TOT);
  localparam int FC_W   = $clog2(COLS);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int MEM_AW = ROW_W + FC_W;
  localparam int WORDS  = ROWS * COLS;

  phase_t             phase;
  logic               take, offset_load, fix_we, done, start;
  logic [COL_W-1:0]   in_col;
  logic [FC_W-1:0]    fix_col;
  logic [ROW_W-1:0]   row;
  logic [PIX_W-1:0]   rd_pix, offset, fix_wdata, mem_q;
  logic               is_frame, is_stat;
  logic [1:0]         sel_q;
  logic               stat_q;

  assign start = bus_wr && (bus_addr == ADDR_W'(CMD_ADDR)) && (bus_wdata == CMD_CAPTURE);

  rowbias_ctrl #(.ROWS(ROWS), .COLS(COLS), .REFS(REFS)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .pix_valid(pix_valid),
    .phase(phase), .take(take), .in_col(in_col), .offset_load(offset_load),
    .fix_we(fix_we), .fix_col(fix_col), .row(row), .done(done)
  );

  rowbias_rowbuf #(.PIX_W(PIX_W), .COLS(COLS), .REFS(REFS)) u_rowbuf (
    .clk(clk), .rst(rst), .take(take), .in_col(in_col), .pix(pix_data),
    .offset_load(offset_load), .rd_col(fix_col), .rd_pix(rd_pix), .offset(offset)
  );

  assign fix_wdata = (rd_pix > offset) ? rd_pix - offset : '0;

  assign is_frame = bus_addr < ADDR_W'(WORDS);
  assign is_stat  = bus_addr == ADDR_W'(STAT_ADDR);

  rowbias_frame_mem #(.DW(PIX_W), .AW(MEM_AW)) u_mem (
    .clk(clk), .we(fix_we), .waddr({row, fix_col}), .wdata(fix_wdata),
    .re(bus_rd && is_frame), .raddr(bus_addr[MEM_AW-1:0]), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 2'd0;
      stat_q <= 1'b0;
    end else if (bus_rd) begin
      sel_q  <= is_frame ? 2'd1 : (is_stat ? 2'd2 : 2'd0);
      stat_q <= done;
    end
  end

  always_comb begin
    case (sel_q)
      2'd1:    bus_rdata = 8'(mem_q);
      2'd2:    bus_rdata = {7'd0, stat_q};
      default: bus_rdata = 8'd0;
    endcase
  end

  // R5
  clamp_chk: assert property (@(posedge clk) disable iff (rst)
    fix_we |-> (fix_wdata <= rd_pix));

  // R6
  write_phase_chk: assert property (@(posedge clk) disable iff (rst)
    fix_we |-> (phase == PH_CORRECT && !take));
endmodule

// File: tb/rowbias_engine_bench.sv
module rowbias_engine_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  pix_data;
  logic        pix_valid;
  logic [15:0] bus_addr;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic        bus_rd;
  logic [7:0]  bus_rdata;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  int exp_mem [4096];

  always #4 clk = ~clk;

  rowbias_engine u_rowbias_engine (
    .clk(clk), .rst(rst), .pix_data(pix_data), .pix_valid(pix_valid),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int addr, input int data);
    @(negedge clk);
    bus_addr = 16'(addr); bus_wdata = 8'(data); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int addr, output int data);
    @(negedge clk);
    bus_addr = 16'(addr); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    data = int'(bus_rdata);
  endtask

  function automatic int ref_a(input int f, input int r);
    case (r % 4)
      0: return 0;
      1: return 200 + f;
      2: return (r * 3 + f) & 63;
      default: return 255;
    endcase
  endfunction

  function automatic int ref_b(input int f, input int r);
    case (r % 4)
      0: return 0;
      1: return 201;
      2: return ((r * 3 + f) & 63) + 7;
      default: return 254 - f;
    endcase
  endfunction

  function automatic int act_pix(input int f, input int r, input int c);
    return (r * 37 + c * 11 + f * 53 + c * c) & 255;
  endfunction

  // R6: strobes during the offset/correction phases, then a gap long enough for R10
  task automatic gap_with_junk(input int junk_cycles);
    for (int i = 0; i < junk_cycles; i++) begin
      @(negedge clk);
      pix_valid = 1'b1; pix_data = 8'(8'hA5 ^ i);
    end
    @(negedge clk);
    pix_valid = 1'b0;
    repeat (70 - junk_cycles) @(negedge clk);
  endtask

  task automatic send_row(input int f, input int r);
    int a, b, bias;
    a = ref_a(f, r); b = ref_b(f, r);
    bias = (a + b) >> 1;
    for (int i = 0; i < 66; i++) begin
      @(negedge clk);
      pix_valid = 1'b1;
      if (i == 0) pix_data = 8'(a);
      else if (i == 1) pix_data = 8'(b);
      else pix_data = 8'(act_pix(f, r, i - 2));
    end
    @(negedge clk);
    pix_valid = 1'b0;
    for (int c = 0; c < 64; c++) begin
      int p;
      p = act_pix(f, r, c);
      exp_mem[r * 64 + c] = (p > bias) ? p - bias : 0;
    end
  endtask

  task automatic compare_frame(input int f);
    int d;
    for (int r = 0; r < 64; r++) begin
      int bias;
      bias = (ref_a(f, r) + ref_b(f, r)) >> 1;
      for (int c = 0; c < 64; c++) begin
        bus_read(r * 64 + c, d);
        if (act_pix(f, r, c) < bias)
          check($sformatf("R5 clamp f%0d row %0d col %0d", f, r, c), d, exp_mem[r * 64 + c]);
        else
          check($sformatf("R3/R4/R8 f%0d row %0d col %0d", f, r, c), d, exp_mem[r * 64 + c]);
      end
    end
  endtask

  // R1
  task automatic t_reset();
    int d;
    check("R1 rdata before any read", int'(bus_rdata), 0);
    bus_read(16'h8001, d);
    check("R1 status after reset", d, 0);
  endtask

  // R6: strobes while idle must not start or affect anything
  task automatic t_idle_strobes();
    int d;
    for (int i = 0; i < 66; i++) begin
      @(negedge clk);
      pix_valid = 1'b1; pix_data = 8'(i * 3);
    end
    @(negedge clk);
    pix_valid = 1'b0;
    bus_read(16'h8001, d);
    check("R6 idle strobes leave status 0", d, 0);
  endtask

  // R2, R7, R9, R10: one full frame; busy_poke issues a capture mid-frame
  task automatic t_frame(input int f, input bit busy_poke);
    int d;
    bus_write(16'h8000, 8'h01);
    bus_read(16'h8001, d);
    check($sformatf("R2 capture clears status f%0d", f), d, 0);
    for (int r = 0; r < 64; r++) begin
      send_row(f, r);
      if (busy_poke && r == 20) bus_write(16'h8000, 8'h01);
      gap_with_junk(30);
      if (r == 40) begin
        bus_read(16'h8001, d);
        check($sformatf("R7 status 0 mid-frame f%0d", f), d, 0);
      end
    end
    bus_read(16'h8001, d);
    check($sformatf("R7 status set after last row f%0d", f), d, 1);
    compare_frame(f);
  endtask

  // R8
  task automatic t_unmapped();
    int d, d2;
    bus_read(16'h4000, d);
    check("R8 unmapped read returns 0", d, 0);
    bus_read(5, d);
    repeat (4) @(negedge clk);
    d2 = int'(bus_rdata);
    check("R8 rdata held between reads", d2, exp_mem[5]);
    bus_write(16'h8000, 8'h02);
    bus_read(16'h8001, d);
    check("R2 other command byte ignored", d, 1);
  endtask

  initial begin
    rst = 1'b1; pix_valid = 1'b0; pix_data = '0;
    bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_idle_strobes();
    t_frame(0, 1'b1);
    t_unmapped();
    t_frame(1, 1'b0); // R9: recapture overwrites
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule